// File: doc/BRIEF.md
# Multi-function requester ID generator

This block holds the routing identity of an endpoint that carries two physical functions (PF0 and PF1), each with its own virtual functions. A simplified capture port records the bus and device numbers that the root complex writes into each PF. When the application layer builds a TLP, it names the owning PF and a function number. One cycle later the block returns the 16-bit requester/completer ID for that TLP, together with a valid flag.

The ID layout depends on the alternative routing-ID mode. With the mode off, the ID is `{bus[7:0], device[4:0], function[2:0]}`, and both the bus and the device number come from the PF that owns the TLP. With the mode on, the ID is `{bus[7:0], function[7:0]}`. In that mode the bus number always comes from PF0, and neither device number has any effect.

The block also drives two size limits to the application: the effective maximum payload size and the effective maximum read request size. Each is the minimum of the corresponding 3-bit field over the PFs that are present. When PF1 is absent, its fields take no part in the minimum.

Top module: `reqid_gen`

## Requirements
- R1: After a synchronous active-low reset, both PFs' captured bus and device numbers are zero and `id_valid` is 0.
- R2: When `cap_valid` is 1, the bus and device numbers on `cap_bus` and `cap_dev` are stored for the PF selected by `cap_pf` (0 = PF0, 1 = PF1) at the next rising edge. The other PF keeps its values, and no values change while `cap_valid` is 0.
- R3: With `ari_en` = 0, the ID is `{bus[req_pf], dev[req_pf], req_func[2:0]}` (bus in bits 15:8, device in bits 7:3, function in bits 2:0). `req_func[7:3]` has no effect.
- R4: With `ari_en` = 1, the ID is `{bus[PF0], req_func[7:0]}`. PF1's bus number and both device numbers have no effect.
- R5: `id_valid` is 1 exactly in the cycle after a cycle in which `req_valid` is 1, and `id_out` changes only in those cycles.
- R6: `eff_mps` equals `mps_pf0` when `pf1_present` = 0, and equals the minimum of `mps_pf0` and `mps_pf1` when `pf1_present` = 1. The output is combinational.
- R7: `eff_mrrs` follows the same rule as R6, applied to `mrrs_pf0` and `mrrs_pf1`.
- R8: A request in the same cycle as a capture to the PF it names returns the ID built from the values held before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_valid | input | 1 | Capture strobe |
| cap_pf | input | 1 | PF targeted by the capture |
| cap_bus | input | 8 | Bus number to capture |
| cap_dev | input | 5 | Device number to capture |
| ari_en | input | 1 | Alternative routing-ID mode enable |
| pf1_present | input | 1 | PF1 takes part in the limit reduction |
| mps_pf0 | input | 3 | PF0 max payload size field |
| mps_pf1 | input | 3 | PF1 max payload size field |
| mrrs_pf0 | input | 3 | PF0 max read request size field |
| mrrs_pf1 | input | 3 | PF1 max read request size field |
| req_valid | input | 1 | ID request strobe |
| req_pf | input | 1 | PF owning the TLP |
| req_func | input | 8 | Function number of the TLP |
| id_valid | output | 1 | ID result valid |
| id_out | output | 16 | Requester/completer ID |
| eff_mps | output | 3 | Effective max payload size |
| eff_mrrs | output | 3 | Effective max read request size |

## Verification
The hardest case to produce from the ports is a request that lands in the same clock as a capture to the PF it names. The returned ID must carry the old bus and device numbers, not the ones being written. The bench drives both strobes in one cycle and expects the previous values. It then makes a second request and expects the new values. To show that each PF's fields really are separate, both PFs are first loaded with distinct bus and device numbers. The bench then issues requests in both modes, with the ignored function bits and the ignored PF1 bus number set to values that would visibly corrupt the ID if they leaked through.

// File: rtl/rid_pkg.sv
// Package: shared widths for the requester ID generator.
// Assumes exactly two PFs; every width below is derived from these constants.
package rid_pkg;
    localparam int NUM_PF = 2;
    localparam int PF_W   = $clog2(NUM_PF);
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;                 // function width when ARI is off
    localparam int AFN_W  = DEV_W + FN_W;      // function width when ARI is on
    localparam int ID_W   = BUS_W + AFN_W;
    localparam int LIM_W  = 3;
endpackage

// File: rtl/rid_capture.sv
// Module: rid_capture
// Holds one PF's bus and device numbers and loads them on a write strobe.
// Assumes the strobe is already decoded for this PF.
module rid_capture
    import rid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [DEV_W-1:0] dev_in,
    output logic [BUS_W-1:0] bus_q,
    output logic [DEV_W-1:0] dev_q
);
    // Purpose: load the routing fields on a strobe, otherwise hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            dev_q <= '0;
        end else if (wr_en) begin
            bus_q <= bus_in;
            dev_q <= dev_in;
        end
    end

    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bus_q) && $stable(dev_q)));
    assert_load_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bus_q == $past(bus_in) && dev_q == $past(dev_in)));
endmodule

// File: rtl/rid_limit_min.sv
// Module: rid_limit_min
// Finds the effective size limit over the PFs that are present.
// Assumes that smaller encodings mean smaller sizes and that PF0 is always present.
module rid_limit_min #(
    parameter int W = 3
) (
    input  logic         pf1_present,
    input  logic [W-1:0] lim_pf0,
    input  logic [W-1:0] lim_pf1,
    output logic [W-1:0] lim_eff
);
    // Purpose: take the minimum when PF1 is present, otherwise pass PF0 through.
    always_comb begin
        if (pf1_present && (lim_pf1 < lim_pf0)) lim_eff = lim_pf1;
        else                                    lim_eff = lim_pf0;
    end

    // Purpose: check that the result never exceeds either contributing field.
    always_comb begin
        assert_not_above_pf0_R6: assert (lim_eff <= lim_pf0);
        if (pf1_present) begin
            assert_not_above_pf1_R7: assert (lim_eff <= lim_pf1);
        end
    end
endmodule

// File: rtl/rid_compose.sv
// Module: rid_compose
// Builds the registered requester ID from the captured fields.
// Assumes the capture registers update at the same edge, so a request sees the values held before that edge.
module rid_compose
    import rid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ari_en,
    input  logic             req_valid,
    input  logic [PF_W-1:0]  req_pf,
    input  logic [AFN_W-1:0] req_func,
    input  logic [BUS_W-1:0] bus_pf0,
    input  logic [BUS_W-1:0] bus_pf1,
    input  logic [DEV_W-1:0] dev_pf0,
    input  logic [DEV_W-1:0] dev_pf1,
    output logic             id_valid,
    output logic [ID_W-1:0]  id_out
);
    logic [BUS_W-1:0] sel_bus;
    logic [DEV_W-1:0] sel_dev;
    logic [ID_W-1:0]  id_next;

    // Purpose: pick the owning PF's fields and lay out the ID for the current mode.
    always_comb begin
        sel_bus = (req_pf == PF_W'(1)) ? bus_pf1 : bus_pf0;
        sel_dev = (req_pf == PF_W'(1)) ? dev_pf1 : dev_pf0;
        if (ari_en) id_next = {bus_pf0, req_func};
        else        id_next = {sel_bus, sel_dev, req_func[FN_W-1:0]};
    end

    // Purpose: register the ID and its valid flag one cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_out   <= '0;
        end else begin
            id_valid <= req_valid;
            if (req_valid) id_out <= id_next;
        end
    end

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> id_valid);
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!id_valid && $stable(id_out)));
    assert_ari_layout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ari_en) |=> (id_out[AFN_W-1:0] == $past(req_func)
                                   && id_out[ID_W-1:AFN_W] == $past(bus_pf0)));
    assert_plain_func_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ari_en) |=> (id_out[FN_W-1:0] == $past(req_func[FN_W-1:0])));
endmodule

// File: rtl/reqid_gen.sv
// Module: reqid_gen (top)
// Captures per-PF routing fields, generates requester IDs and reduces the size limits.
// Assumes two PFs, with PF0 always present.
module reqid_gen
    import rid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic             cap_pf,
    input  logic [BUS_W-1:0] cap_bus,
    input  logic [DEV_W-1:0] cap_dev,
    input  logic             ari_en,
    input  logic             pf1_present,
    input  logic [LIM_W-1:0] mps_pf0,
    input  logic [LIM_W-1:0] mps_pf1,
    input  logic [LIM_W-1:0] mrrs_pf0,
    input  logic [LIM_W-1:0] mrrs_pf1,
    input  logic             req_valid,
    input  logic             req_pf,
    input  logic [AFN_W-1:0] req_func,
    output logic             id_valid,
    output logic [ID_W-1:0]  id_out,
    output logic [LIM_W-1:0] eff_mps,
    output logic [LIM_W-1:0] eff_mrrs
);
    logic [BUS_W-1:0] bus_arr [NUM_PF];
    logic [DEV_W-1:0] dev_arr [NUM_PF];

    // One capture register set per PF, each written only by its own decoded strobe.
    for (genvar g = 0; g < NUM_PF; g++) begin : g_pf
        rid_capture u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cap_valid && (cap_pf == 1'(g))),
            .bus_in (cap_bus),
            .dev_in (cap_dev),
            .bus_q  (bus_arr[g]),
            .dev_q  (dev_arr[g])
        );
    end

    rid_compose u_compose (
        .clk      (clk),
        .rst_n    (rst_n),
        .ari_en   (ari_en),
        .req_valid(req_valid),
        .req_pf   (req_pf),
        .req_func (req_func),
        .bus_pf0  (bus_arr[0]),
        .bus_pf1  (bus_arr[1]),
        .dev_pf0  (dev_arr[0]),
        .dev_pf1  (dev_arr[1]),
        .id_valid (id_valid),
        .id_out   (id_out)
    );

    rid_limit_min #(.W(LIM_W)) u_mps (
        .pf1_present(pf1_present),
        .lim_pf0    (mps_pf0),
        .lim_pf1    (mps_pf1),
        .lim_eff    (eff_mps)
    );

    rid_limit_min #(.W(LIM_W)) u_mrrs (
        .pf1_present(pf1_present),
        .lim_pf0    (mrrs_pf0),
        .lim_pf1    (mrrs_pf1),
        .lim_eff    (eff_mrrs)
    );

    assert_pf0_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pf1_present |-> (eff_mps == mps_pf0 && eff_mrrs == mrrs_pf0));
endmodule

// File: tb/reqid_gen_tb.sv
module reqid_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cap_valid, cap_pf, ari_en, pf1_present, req_valid, req_pf;
    logic [7:0]  cap_bus, req_func;
    logic [4:0]  cap_dev;
    logic [2:0]  mps_pf0, mps_pf1, mrrs_pf0, mrrs_pf1, eff_mps, eff_mrrs;
    logic        id_valid;
    logic [15:0] id_out;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reqid_gen u_dut (.*);

    // Limit vectors: {field0, field1, pf1 present, expected minimum}
    localparam logic [9:0] LIM_VEC [8] = '{
        {3'd2, 3'd5, 1'b1, 3'd2}, {3'd5, 3'd2, 1'b1, 3'd2},
        {3'd5, 3'd2, 1'b0, 3'd5}, {3'd0, 3'd7, 1'b1, 3'd0},
        {3'd7, 3'd0, 1'b1, 3'd0}, {3'd7, 3'd0, 1'b0, 3'd7},
        {3'd3, 3'd3, 1'b1, 3'd3}, {3'd1, 3'd4, 1'b0, 3'd1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic capture(input logic pf, input logic [7:0] b, input logic [4:0] d);
        @(negedge clk);
        cap_valid = 1'b1; cap_pf = pf; cap_bus = b; cap_dev = d;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic request(input logic ari, input logic pf, input logic [7:0] fn,
                           input string req, input logic [15:0] exp);
        @(negedge clk);
        ari_en = ari; req_valid = 1'b1; req_pf = pf; req_func = fn;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {15'd0, id_valid}, 16'd1);
        check(req, id_out, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; cap_valid = 0; cap_pf = 0; cap_bus = 0; cap_dev = 0;
        ari_en = 0; pf1_present = 1; req_valid = 0; req_pf = 0; req_func = 0;
        mps_pf0 = 0; mps_pf1 = 0; mrrs_pf0 = 0; mrrs_pf1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 valid low after reset", {15'd0, id_valid}, 16'd0);

        // Limit table, R6 and R7 (mrrs driven with the fields swapped)
        foreach (LIM_VEC[i]) begin
            {mps_pf0, mps_pf1, pf1_present} = LIM_VEC[i][9:3];
            mrrs_pf0 = LIM_VEC[i][6:4]; mrrs_pf1 = LIM_VEC[i][9:7];
            #1;
            check("R6 eff_mps", {13'd0, eff_mps}, {13'd0, LIM_VEC[i][2:0]});
            check("R7 eff_mrrs", {13'd0, eff_mrrs},
                  {13'd0, pf1_present ? LIM_VEC[i][2:0] : LIM_VEC[i][6:4]});
        end

        // R1: zero fields after reset, seen through a non-ARI request
        request(1'b0, 1'b1, 8'h05, "R1 zero fields PF1", 16'h0005);

        // R2: per-PF capture
        capture(1'b0, 8'h3C, 5'h0A);
        request(1'b0, 1'b1, 8'h00, "R2 PF1 untouched", 16'h0000);
        capture(1'b1, 8'hC5, 5'h13);
        request(1'b0, 1'b0, 8'h02, "R2 R3 PF0 id", {8'h3C, 5'h0A, 3'd2});
        request(1'b0, 1'b1, 8'hFF, "R3 PF1 id upper func ignored", {8'hC5, 5'h13, 3'd7});

        // R4: ARI layout uses PF0 bus only
        request(1'b1, 1'b1, 8'hA7, "R4 ARI PF1 uses PF0 bus", {8'h3C, 8'hA7});
        request(1'b1, 1'b0, 8'h81, "R4 ARI PF0", {8'h3C, 8'h81});

        // R5: valid drops and ID holds without a request
        @(negedge clk);
        check("R5 valid low idle", {15'd0, id_valid}, 16'd0);
        check("R5 id held idle", id_out, {8'h3C, 8'h81});

        // R8: request and capture to the same PF in one cycle
        @(negedge clk);
        cap_valid = 1; cap_pf = 1; cap_bus = 8'h11; cap_dev = 5'h1F;
        ari_en = 0; req_valid = 1; req_pf = 1; req_func = 8'h03;
        @(negedge clk);
        cap_valid = 0; req_valid = 0;
        check("R8 old fields used", id_out, {8'hC5, 5'h13, 3'd3});
        request(1'b0, 1'b1, 8'h03, "R8 new fields next", {8'h11, 5'h1F, 3'd3});

        // R1: reset clears the captured fields again
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check("R1 valid low after second reset", {15'd0, id_valid}, 16'd0);
        request(1'b0, 1'b0, 8'h01, "R1 PF0 cleared", 16'h0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule